// File: doc/BRIEF.md
# Memory Protection Region Checker

This block decides, for every memory access, whether the access may proceed. It compares the access address against eight programmable protection regions. Each region has an enable bit and a power-of-two size. The highest-numbered region that is enabled and matches is the one that counts. A packed table of 4-bit permission codes then gives the read and write rights for that region. The table used depends on whether the access is an instruction fetch or a data access. Each code can give privileged and user accesses different rights.

An access that matches no region raises a background fault. An access whose code forbids it, or whose requested read or write is not granted, raises a permission fault. The address always passes through untranslated. A global disable turns the block into a pass-through that grants everything.

The decision is combinational. An optional output register stage, on by default, adds one cycle of latency and a valid strobe.

Top module: `mpu_region_check`

## Requirements
- R1: When `mpuEnable` is 0, every grant is 1, `fault` is 0, `faultKind` is 0 and `faultLevel` is 0, whatever the region and permission inputs are.
- R2: `addrOut` always equals the `addrIn` of the same request.
- R3: Bit 0 of a region word enables that region. A region whose bit 0 is 0 never matches, even when its address bits agree.
- R4: Bits 5:1 of a region word hold N. The region matches when the whole region word and the address agree in every bit above the low mask 2^(N+1)-1. With N = 31 every address matches.
- R5: When several enabled regions match, the one with the highest index alone supplies the permission code.
- R6: If no enabled region matches, `fault` is 1, `faultKind` is 1 (background), `faultLevel` is 0, and all grants are 0.
- R7: A fetch (`isFetch` = 1) reads the code of region n from `instPerm[4n+3:4n]`. Any other access reads it from `dataPerm[4n+3:4n]`.
- R8: The codes decode as follows, giving privileged / user rights: 0 none/none; 1 read-write/none; 2 read-write/read; 3 read-write/read-write; 5 read/none; 6 read/read. Any other code gives no rights. An access with no read right faults.
- R9: A permission fault gives `fault` = 1, `faultKind` = 2 and `faultLevel` = 1. Any fault forces all three grants to 0.
- R10: When `wantWrite` = 1 and the write right is missing, the access is a permission fault. The same holds for `wantRead` = 1 when the read right is missing.
- R11: An access without a fault has `grantExec` = 1, and its read and write grants equal the decoded rights.
- R12: With `OUT_REG` = 1, the results of a request appear one clock after it, and `respValid` is `reqValid` delayed by one clock. Reset clears `respValid`, the grants and the fault outputs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low asynchronous reset |
| mpuEnable | input | 1 | Global enable of the protection check |
| reqValid | input | 1 | Request strobe |
| addrIn | input | 32 | Access address |
| isFetch | input | 1 | 1 for an instruction fetch, 0 for a data access |
| isPriv | input | 1 | 1 for a privileged access, 0 for a user access |
| wantRead | input | 1 | The access requests a read |
| wantWrite | input | 1 | The access requests a write |
| regionCfg | input | 256 | Eight packed region words; region n is bits [32n+31:32n] |
| instPerm | input | 32 | Fetch permission codes, 4 bits per region |
| dataPerm | input | 32 | Data permission codes, 4 bits per region |
| addrOut | output | 32 | Untranslated output address |
| grantRead | output | 1 | Read granted |
| grantWrite | output | 1 | Write granted |
| grantExec | output | 1 | Execute granted |
| fault | output | 1 | Access faults |
| faultKind | output | 2 | 0 none, 1 background, 2 permission |
| faultLevel | output | 2 | 1 for a permission fault, otherwise 0 |
| respValid | output | 1 | Result valid |

## Verification
The assertions check the following on every cycle: the pass-through when the block is disabled, the background fault on a miss, the rule that a fault clears all grants, the rule that at most one fault class is active, the all-matching region at N = 31, and the one-cycle valid latency. Other behaviour depends on the actual values and can only be shown by the bench's sweeps: the permission value read for every code, privilege and access kind, the choice between the instruction and data tables, the priority across all 255 enable patterns, and the match boundary for every size exponent.

// File: rtl/mpu_pkg.sv
package mpu_pkg;
  localparam int unsigned PERM_W = 4;

  typedef enum logic [1:0] {
    FAULT_NONE       = 2'd0,
    FAULT_BACKGROUND = 2'd1,
    FAULT_PERMISSION = 2'd2
  } faultKindE;

  // Strobes handed from the decision logic to the datapath.
  typedef struct packed {
    logic grantRead;
    logic grantWrite;
    logic grantExec;
    logic faultBg;
    logic faultPerm;
  } verdictT;
endpackage

// File: rtl/mpu_ctrl.sv
module mpu_ctrl
  import mpu_pkg::*;
#(
  parameter int unsigned NUM_REGIONS = 8
) (
  input  logic                          clk,
  input  logic                          rstN,
  input  logic                          mpuEnable,
  input  logic                          isFetch,
  input  logic                          isPriv,
  input  logic                          wantRead,
  input  logic                          wantWrite,
  input  logic [NUM_REGIONS-1:0]        hitVec,
  input  logic [NUM_REGIONS*PERM_W-1:0] instPerm,
  input  logic [NUM_REGIONS*PERM_W-1:0] dataPerm,
  output verdictT                       verdict
);
  localparam int unsigned IDX_W = (NUM_REGIONS > 1) ? $clog2(NUM_REGIONS) : 1;

  logic [IDX_W-1:0]              winIdx;
  logic                          anyHit;
  logic [NUM_REGIONS*PERM_W-1:0] permSrc;
  logic [PERM_W-1:0]             permCode;
  logic                          rightRead;
  logic                          rightWrite;

  // Ascending scan: the last hit seen, which is the highest index, wins.
  always_comb begin
    winIdx = '0;
    anyHit = 1'b0;
    for (int i = 0; i < NUM_REGIONS; i++) begin
      if (hitVec[i]) begin
        winIdx = IDX_W'(i);
        anyHit = 1'b1;
      end
    end
  end

  assign permSrc  = isFetch ? instPerm : dataPerm;
  assign permCode = permSrc[winIdx*PERM_W +: PERM_W];

  always_comb begin
    rightRead  = 1'b0;
    rightWrite = 1'b0;
    case (permCode)
      4'd1: begin rightRead = isPriv; rightWrite = isPriv; end
      4'd2: begin rightRead = 1'b1;   rightWrite = isPriv; end
      4'd3: begin rightRead = 1'b1;   rightWrite = 1'b1;   end
      4'd5: begin rightRead = isPriv; rightWrite = 1'b0;   end
      4'd6: begin rightRead = 1'b1;   rightWrite = 1'b0;   end
      default: begin rightRead = 1'b0; rightWrite = 1'b0;  end
    endcase
  end

  always_comb begin
    verdict = '0;
    if (!mpuEnable) begin
      verdict.grantRead  = 1'b1;
      verdict.grantWrite = 1'b1;
      verdict.grantExec  = 1'b1;
    end else if (!anyHit) begin
      verdict.faultBg = 1'b1;
    end else if (!rightRead || (wantWrite && !rightWrite) || (wantRead && !rightRead)) begin
      verdict.faultPerm = 1'b1;
    end else begin
      verdict.grantRead  = rightRead;
      verdict.grantWrite = rightWrite;
      verdict.grantExec  = 1'b1;
    end
  end

  a_r1_disabled_open: assert property (@(posedge clk) disable iff (!rstN)
    !mpuEnable |-> (verdict.grantRead && verdict.grantWrite && verdict.grantExec
                    && !verdict.faultBg && !verdict.faultPerm));

  a_r6_miss_background: assert property (@(posedge clk) disable iff (!rstN)
    (mpuEnable && (hitVec == '0)) |-> verdict.faultBg);

  a_r9_fault_no_grant: assert property (@(posedge clk) disable iff (!rstN)
    (verdict.faultBg || verdict.faultPerm) |->
      !(verdict.grantRead || verdict.grantWrite || verdict.grantExec));

  a_r9_single_class: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({verdict.faultBg, verdict.faultPerm}));
endmodule

// File: rtl/mpu_match_dp.sv
module mpu_match_dp
  import mpu_pkg::*;
#(
  parameter int unsigned NUM_REGIONS = 8,
  parameter int unsigned ADDR_W      = 32,
  parameter int unsigned SIZE_W      = 5,
  parameter bit          OUT_REG     = 1'b1
) (
  input  logic                          clk,
  input  logic                          rstN,
  input  logic                          reqValid,
  input  logic [ADDR_W-1:0]             addrIn,
  input  logic [NUM_REGIONS*ADDR_W-1:0] regionCfg,
  input  verdictT                       verdict,
  output logic [NUM_REGIONS-1:0]        hitVec,
  output logic [ADDR_W-1:0]             addrOut,
  output logic                          grantRead,
  output logic                          grantWrite,
  output logic                          grantExec,
  output logic                          fault,
  output logic [1:0]                    faultKind,
  output logic [1:0]                    faultLevel,
  output logic                          respValid
);
  localparam int unsigned SHIFT_W = SIZE_W + 1;

  typedef struct packed {
    logic [ADDR_W-1:0] addr;
    logic              gRead;
    logic              gWrite;
    logic              gExec;
    logic              flt;
    faultKindE         kind;
    logic [1:0]        level;
    logic              valid;
  } respT;

  for (genvar g = 0; g < NUM_REGIONS; g++) begin : gRegion
    logic [ADDR_W-1:0]  cfgWord;
    logic [SIZE_W-1:0]  sizeExp;
    logic [SHIFT_W-1:0] spanBits;
    logic [ADDR_W-1:0]  lowMask;

    assign cfgWord  = regionCfg[g*ADDR_W +: ADDR_W];
    assign sizeExp  = cfgWord[SIZE_W:1];
    // One bit wider so that N = 31 gives a shift of 32 and an all-ones mask.
    assign spanBits = {1'b0, sizeExp} + SHIFT_W'(1);
    assign lowMask  = ~({ADDR_W{1'b1}} << spanBits);
    assign hitVec[g] = cfgWord[0] && (((cfgWord ^ addrIn) & ~lowMask) == '0);

    a_r4_full_span: assert property (@(posedge clk) disable iff (!rstN)
      (cfgWord[0] && (&sizeExp)) |-> hitVec[g]);

    a_r3_disabled_nohit: assert property (@(posedge clk) disable iff (!rstN)
      !cfgWord[0] |-> !hitVec[g]);
  end

  respT nextResp;
  respT curResp;

  always_comb begin
    nextResp        = '0;
    nextResp.addr   = addrIn;
    nextResp.gRead  = verdict.grantRead;
    nextResp.gWrite = verdict.grantWrite;
    nextResp.gExec  = verdict.grantExec;
    nextResp.flt    = verdict.faultBg | verdict.faultPerm;
    nextResp.kind   = verdict.faultPerm ? FAULT_PERMISSION :
                      verdict.faultBg   ? FAULT_BACKGROUND : FAULT_NONE;
    nextResp.level  = verdict.faultPerm ? 2'd1 : 2'd0;
    nextResp.valid  = reqValid;
  end

  if (OUT_REG) begin : gReg
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) curResp <= '0;
      else       curResp <= nextResp;
    end

    a_r12_one_cycle: assert property (@(posedge clk) disable iff (!rstN)
      reqValid |=> respValid);
  end else begin : gComb
    assign curResp = nextResp;
  end

  assign addrOut    = curResp.addr;
  assign grantRead  = curResp.gRead;
  assign grantWrite = curResp.gWrite;
  assign grantExec  = curResp.gExec;
  assign fault      = curResp.flt;
  assign faultKind  = curResp.kind;
  assign faultLevel = curResp.level;
  assign respValid  = curResp.valid;
endmodule

// File: rtl/mpu_region_check.sv
module mpu_region_check
  import mpu_pkg::*;
#(
  parameter int unsigned NUM_REGIONS = 8,
  parameter int unsigned ADDR_W      = 32,
  parameter int unsigned SIZE_W      = 5,
  parameter bit          OUT_REG     = 1'b1
) (
  input  logic                          clk,
  input  logic                          rstN,
  input  logic                          mpuEnable,
  input  logic                          reqValid,
  input  logic [ADDR_W-1:0]             addrIn,
  input  logic                          isFetch,
  input  logic                          isPriv,
  input  logic                          wantRead,
  input  logic                          wantWrite,
  input  logic [NUM_REGIONS*ADDR_W-1:0] regionCfg,
  input  logic [NUM_REGIONS*PERM_W-1:0] instPerm,
  input  logic [NUM_REGIONS*PERM_W-1:0] dataPerm,
  output logic [ADDR_W-1:0]             addrOut,
  output logic                          grantRead,
  output logic                          grantWrite,
  output logic                          grantExec,
  output logic                          fault,
  output logic [1:0]                    faultKind,
  output logic [1:0]                    faultLevel,
  output logic                          respValid
);
  logic [NUM_REGIONS-1:0] hitVec;
  verdictT                verdict;

  mpu_ctrl #(.NUM_REGIONS(NUM_REGIONS)) ctrl_i (
    .clk(clk), .rstN(rstN), .mpuEnable(mpuEnable), .isFetch(isFetch),
    .isPriv(isPriv), .wantRead(wantRead), .wantWrite(wantWrite),
    .hitVec(hitVec), .instPerm(instPerm), .dataPerm(dataPerm),
    .verdict(verdict)
  );

  mpu_match_dp #(
    .NUM_REGIONS(NUM_REGIONS), .ADDR_W(ADDR_W), .SIZE_W(SIZE_W), .OUT_REG(OUT_REG)
  ) dp_i (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .addrIn(addrIn),
    .regionCfg(regionCfg), .verdict(verdict), .hitVec(hitVec),
    .addrOut(addrOut), .grantRead(grantRead), .grantWrite(grantWrite),
    .grantExec(grantExec), .fault(fault), .faultKind(faultKind),
    .faultLevel(faultLevel), .respValid(respValid)
  );
endmodule

// File: tb/mpu_region_check_tb.sv
module mpu_region_check_tb_top;
  localparam int CLK_PERIOD = 10;

  logic         clk = 1'b0;
  logic         rstN = 1'b0;
  logic         mpuEnable = 1'b0;
  logic         reqValid = 1'b0;
  logic [31:0]  addrIn = '0;
  logic         isFetch = 1'b0;
  logic         isPriv = 1'b0;
  logic         wantRead = 1'b0;
  logic         wantWrite = 1'b0;
  logic [255:0] regionCfg = '0;
  logic [31:0]  instPerm = '0;
  logic [31:0]  dataPerm = '0;
  logic [31:0]  addrOut;
  logic         grantRead, grantWrite, grantExec, fault, respValid;
  logic [1:0]   faultKind, faultLevel;

  int checks = 0;
  int errors = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  mpu_region_check dut_i (
    .clk(clk), .rstN(rstN), .mpuEnable(mpuEnable), .reqValid(reqValid),
    .addrIn(addrIn), .isFetch(isFetch), .isPriv(isPriv), .wantRead(wantRead),
    .wantWrite(wantWrite), .regionCfg(regionCfg), .instPerm(instPerm),
    .dataPerm(dataPerm), .addrOut(addrOut), .grantRead(grantRead),
    .grantWrite(grantWrite), .grantExec(grantExec), .fault(fault),
    .faultKind(faultKind), .faultLevel(faultLevel), .respValid(respValid)
  );

  // Expected outputs as {addr, r, w, x, fault, kind, level, valid}.
  function automatic logic [40:0] model();
    int win = -1;
    logic [3:0] code;
    logic r, w, bad;
    if (!mpuEnable) return {addrIn, 1'b1, 1'b1, 1'b1, 1'b0, 2'd0, 2'd0, 1'b1};
    for (int k = 7; k >= 0; k--) begin
      logic [63:0] word, diff;
      int sh;
      word = {32'b0, regionCfg[k*32 +: 32]};
      sh = int'(word[5:1]) + 1;
      diff = (word ^ {32'b0, addrIn}) >> sh;
      if (word[0] && diff == 64'd0) begin win = k; break; end
    end
    if (win < 0) return {addrIn, 1'b0, 1'b0, 1'b0, 1'b1, 2'd1, 2'd0, 1'b1};
    code = isFetch ? instPerm[win*4 +: 4] : dataPerm[win*4 +: 4];
    case (code)
      4'd1: begin r = isPriv; w = isPriv; end
      4'd2: begin r = 1'b1;   w = isPriv; end
      4'd3: begin r = 1'b1;   w = 1'b1;   end
      4'd5: begin r = isPriv; w = 1'b0;   end
      4'd6: begin r = 1'b1;   w = 1'b0;   end
      default: begin r = 1'b0; w = 1'b0; end
    endcase
    bad = !r || (wantWrite && !w) || (wantRead && !r);
    if (bad) return {addrIn, 1'b0, 1'b0, 1'b0, 1'b1, 2'd2, 2'd1, 1'b1};
    return {addrIn, r, w, 1'b1, 1'b0, 2'd0, 2'd0, 1'b1};
  endfunction

  // Drives at a falling edge; result sampled at the next falling edge.
  task automatic apply(input string tag);
    logic [40:0] expv;
    logic [40:0] actv;
    reqValid = 1'b1;
    expv = model();
    @(negedge clk);
    actv = {addrOut, grantRead, grantWrite, grantExec, fault, faultKind, faultLevel, respValid};
    checks++;
    if (actv !== expv) begin
      errors++;
      $display("FAIL %s act=%h exp=%h", tag, actv, expv);
    end
  endtask

  initial begin : watchdog
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin : main
    repeat (3) @(negedge clk);
    // R12: reset state
    checks++;
    if ({respValid, grantRead, grantWrite, grantExec, fault} !== 5'b0) begin
      errors++;
      $display("FAIL R12 reset act=%b exp=00000",
               {respValid, grantRead, grantWrite, grantExec, fault});
    end
    rstN = 1'b1;
    @(negedge clk);

    // R1/R2: disabled unit passes everything
    mpuEnable = 1'b0;
    for (int i = 0; i < 8; i++) begin
      addrIn = 32'h1357_9BDF * (i + 1);
      wantWrite = i[0]; isPriv = i[1];
      apply(i[2] ? "R2" : "R1");
    end

    // R7..R11: every code, privilege, access kind and request mix
    mpuEnable = 1'b1;
    regionCfg = '0;
    regionCfg[31:0] = {26'b0, 5'd31, 1'b1};
    for (int c = 0; c < 16; c++) begin
      for (int m = 0; m < 16; m++) begin
        logic [40:0] e;
        instPerm = {28'b0, 4'(c)};
        dataPerm = {28'b0, 4'(15 - c)};
        isFetch = m[0]; isPriv = m[1]; wantRead = m[2]; wantWrite = m[3];
        addrIn = 32'hC0DE_0000 + 32'(c * 16 + m);
        e = model();
        if (e[4]) apply("R9");
        else if (m[0] && !(m[2] | m[3])) apply("R7");
        else if (m[2] | m[3]) apply("R10");
        else if (m[1]) apply("R11");
        else apply("R8");
      end
    end

    // R5/R6: priority over every enable pattern
    isFetch = 1'b0; isPriv = 1'b0; wantRead = 1'b1; wantWrite = 1'b1;
    for (int p = 0; p < 256; p++) begin
      int top = -1;
      regionCfg = '0;
      dataPerm = '0;
      for (int k = 0; k < 8; k++) begin
        if (p[k]) begin
          regionCfg[k*32 +: 32] = {26'b0, 5'd31, 1'b1};
          top = k;
        end
      end
      if (top >= 0) dataPerm[top*4 +: 4] = 4'd3;
      addrIn = 32'h0F0F_0000 ^ 32'(p);
      apply(p == 0 ? "R6" : "R5");
    end

    // R3: region 7 disabled but aligned, region 0 covers all
    regionCfg = '0;
    regionCfg[0 +: 32]   = {26'b0, 5'd31, 1'b1};
    regionCfg[224 +: 32] = {26'b0, 5'd31, 1'b0};
    dataPerm = 32'h3000_0006;
    wantRead = 1'b1; wantWrite = 1'b0; isPriv = 1'b1;
    addrIn = 32'h8000_0040;
    apply("R3");
    wantWrite = 1'b1;
    apply("R3");
    regionCfg[0 +: 32] = '0;
    apply("R6");

    // R4: size boundary for every exponent, region 2 only
    wantWrite = 1'b0;
    dataPerm = 32'h0000_0300;
    for (int n = 0; n < 32; n++) begin
      logic [31:0] word;
      regionCfg = '0;
      word = {26'h296_1DF8 ^ 26'(n * 977), 5'(n), 1'b1};
      regionCfg[64 +: 32] = word;
      addrIn = word;
      apply("R4");
      addrIn = word ^ (32'd1 << n);
      apply("R4");
      if (n < 31) begin
        addrIn = word ^ (32'd1 << (n + 1));
        apply("R4");
      end
    end

    // R12: no request gives no valid
    reqValid = 1'b0;
    @(negedge clk);
    checks++;
    if (respValid !== 1'b0) begin
      errors++;
      $display("FAIL R12 respValid act=%b exp=0", respValid);
    end

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule